// File: doc/BRIEF.md
# Conditional Short Branch Unit

This block resolves a two-byte relative branch from the 0x20 to 0x2F opcode group. A start strobe captures the opcode, an 8-bit signed displacement, the address of the branch instruction and the four status flags N, Z, V and C. From these the block works out whether the branch is taken, the next program counter and the number of cycles the instruction uses.

The low three bits of the opcode above bit 0 pick one of eight tests: always, unsigned higher, carry clear, not equal, overflow clear, plus, signed greater-or-equal and signed greater. Opcode bit 0 inverts the test that was picked. A small sequencer then stays busy for three cycles when the branch is taken or for one cycle when it is not. It raises `done` in the last busy cycle. The status flags pass through without change.

The block is used next to the pipeline's control logic. The fetch unit takes `pc_next` when `done` is high.

Top module: `short_branch_unit`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted start, `busy`, `done`, `taken` and `illegal` are 0.
- R2: The next PC is computed modulo 2^16. For a taken branch it is the instruction address plus 2 plus the sign-extended displacement. Otherwise it is the instruction address plus 2. This holds across the 0x0000/0xFFFF boundary.
- R3: The flag input is packed as {N,Z,V,C}, with N in bit 3 and C in bit 0. Opcode 0x20 always branches and 0x21 never branches. 0x22 branches when (C|Z)=0 and 0x23 when (C|Z)=1. 0x24 branches when C=0 and 0x25 when C=1. 0x26 branches when Z=0 and 0x27 when Z=1.
- R4: Opcode 0x28 branches when V=0 and 0x29 when V=1. Opcode 0x2A branches when N=0 and 0x2B when N=1.
- R5: Opcode 0x2C branches when (N^V)=0 and 0x2D when (N^V)=1. Opcode 0x2E branches when (Z|(N^V))=0 and 0x2F when it is 1.
- R6: An accepted start at a clock edge makes `busy` high from the next cycle. A taken branch stays busy for 3 cycles and a not-taken branch for 1 cycle. `done` is high only in the last busy cycle. `cycles` reads 3 for a taken branch and 1 for a not-taken one.
- R7: `flags_out` equals the flag input captured at the accepted start. The branch changes no flag.
- R8: An opcode whose upper nibble is not 2 sets `illegal` to 1 and `taken` to 0. Its next PC is the address plus 2, and it takes 1 cycle.
- R9: A start while `busy` is high is ignored. `taken`, `pc_next`, `cycles`, `illegal` and `flags_out` hold from the accepted start until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the inputs when idle |
| opcode | input | 8 | Branch opcode |
| disp | input | 8 | Signed displacement |
| pc_in | input | 16 | Address of the branch instruction |
| flags | input | 4 | {N,Z,V,C} |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |
| taken | output | 1 | Branch condition met |
| illegal | output | 1 | Opcode outside the group |
| pc_next | output | 16 | Next program counter |
| cycles | output | 2 | Cycle count of the instruction |
| flags_out | output | 4 | Status flags after the branch (unchanged) |

## Verification
The bench runs all sixteen opcodes against every one of the sixteen flag combinations. A design that mixed up the signed and unsigned tests, or dropped the bit-0 inversion, would report the wrong `taken` for some pairs. Displacements of 0x7F, 0x80 and 0xFF near addresses 0x0000 and 0xFFFF expose missing sign extension or a carry that leaks past bit 15. Starts held high through the busy window would show a design that re-captures its inputs mid-instruction through changing outputs or an extra busy cycle. Illegal opcodes chosen with flags that would satisfy a branch show whether the group decode is applied.

// File: rtl/short_branch_unit.sv
module short_branch_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [7:0]    disp,
  input  logic [AW-1:0] pc_in,
  input  logic [3:0]    flags,
  output logic          busy,
  output logic          done,
  output logic          taken,
  output logic          illegal,
  output logic [AW-1:0] pc_next,
  output logic [1:0]    cycles,
  output logic [3:0]    flags_out
);

  logic fn, fz, fv, fc, nxv;
  logic base, cond, bad, go;
  logic [1:0] left;
  logic [AW-1:0] offs;

  assign {fn, fz, fv, fc} = flags;
  assign nxv = fn ^ fv;
  assign bad = opcode[7:4] != 4'h2;

  always_comb begin
    case (opcode[3:1])
      3'd0: base = 1'b1;
      3'd1: base = ~(fc | fz);
      3'd2: base = ~fc;
      3'd3: base = ~fz;
      3'd4: base = ~fv;
      3'd5: base = ~fn;
      3'd6: base = ~nxv;
      default: base = ~(fz | nxv);
    endcase
  end

  assign cond = base ^ opcode[0];
  assign go   = cond & ~bad;
  assign offs = go ? {{(AW-8){disp[7]}}, disp} : '0;
  assign done = busy & (left == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      left      <= 2'd0;
      taken     <= 1'b0;
      illegal   <= 1'b0;
      pc_next   <= '0;
      cycles    <= 2'd0;
      flags_out <= 4'd0;
    end else if (start && !busy) begin
      busy      <= 1'b1;
      left      <= go ? 2'd2 : 2'd0;
      taken     <= go;
      illegal   <= bad;
      pc_next   <= pc_in + AW'(2) + offs;
      cycles    <= go ? 2'd3 : 2'd1;
      flags_out <= flags;
    end else if (busy) begin
      if (left == 2'd0) busy <= 1'b0;
      else left <= left - 2'd1;
    end
  end

endmodule

module short_branch_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          taken,
  input logic          illegal,
  input logic [AW-1:0] pc_next,
  input logic [1:0]    cycles
);
  a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r6_taken_not_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && taken) |-> !done);
  a_r6_taken_second: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && taken) |=> (busy && !done));
  a_r6_nottaken_single: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !taken) |-> done);
  a_r6_cycles_match: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cycles == (taken ? 2'd3 : 2'd1)));
  a_r8_illegal_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && illegal) |-> !taken);
  a_r9_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(done)) |-> $stable(pc_next));
endmodule

bind short_branch_unit short_branch_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .taken(taken),
  .illegal(illegal), .pc_next(pc_next), .cycles(cycles)
);

// File: tb/short_branch_unit_test.sv
module short_branch_unit_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] opcode = 0, disp = 0;
  logic [15:0] pc_in = 0;
  logic [3:0] flags = 0;
  logic busy, done, taken, illegal;
  logic [15:0] pc_next;
  logic [1:0] cycles;
  logic [3:0] flags_out;

  int total = 0, bad = 0, ncyc = 0;
  int e_left = 0;
  bit e_taken = 0, e_ill = 0;
  int e_pc = 0, e_cyc = 0, e_flags = 0;
  int e_op = 0;
  bit started = 0;

  always #10 clk = ~clk;

  short_branch_unit uut (.*);

  function automatic bit ref_taken(int op, int f);
    bit n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (op)
      'h20: return 1;
      'h21: return 0;
      'h22: return (c | z) == 0;
      'h23: return (c | z) == 1;
      'h24: return c == 0;
      'h25: return c == 1;
      'h26: return z == 0;
      'h27: return z == 1;
      'h28: return v == 0;
      'h29: return v == 1;
      'h2A: return n == 0;
      'h2B: return n == 1;
      'h2C: return (n ^ v) == 0;
      'h2D: return (n ^ v) == 1;
      'h2E: return (z | (n ^ v)) == 0;
      'h2F: return (z | (n ^ v)) == 1;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int op);
    if (op < 'h20 || op > 'h2F) return "R8";
    if (op < 'h28) return "R3";
    if (op < 'h2C) return "R4";
    return "R5";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_left <= 0; e_taken <= 0; e_ill <= 0; e_pc <= 0; e_cyc <= 0; e_flags <= 0;
      started <= 0;
    end else if (start && e_left == 0) begin
      bit t;
      int d;
      t = ref_taken(opcode, flags);
      d = disp[7] ? int'(disp) - 256 : int'(disp);
      started <= 1;
      e_op <= opcode;
      e_taken <= t;
      e_ill <= (opcode < 8'h20 || opcode > 8'h2F);
      e_pc <= (int'(pc_in) + 2 + (t ? d : 0)) & 'hFFFF;
      e_cyc <= t ? 3 : 1;
      e_left <= t ? 3 : 1;
      e_flags <= flags;
    end else if (e_left > 0) begin
      e_left <= e_left - 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    string rq;
    rq = (!rst_n || !started) ? "R1" : "R6";
    chk(rq, "busy", busy, e_left > 0);
    chk(rq, "done", done, e_left == 1);
    chk(started ? tag_of(e_op) : "R1", "taken", taken, e_taken);
    chk(started ? "R8" : "R1", "illegal", illegal, e_ill);
    if (started) begin
      chk("R2", "pc_next", pc_next, e_pc);
      chk("R6", "cycles", cycles, e_cyc);
      chk("R7", "flags_out", flags_out, e_flags);
    end
  end

  task automatic issue(int op, int d, int pc, int f, bit hold);
    @(negedge clk);
    opcode = op[7:0]; disp = d[7:0]; pc_in = pc[15:0]; flags = f[3:0]; start = 1;
    @(negedge clk);
    // R9: keep start high and scramble inputs while busy
    if (hold) begin
      opcode = $urandom; disp = $urandom; pc_in = $urandom; flags = $urandom;
    end else start = 0;
    while (e_left > 0) @(negedge clk);
    start = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int op = 'h20; op <= 'h2F; op++)
      for (int f = 0; f < 16; f++)
        issue(op, (op * 37 + f * 11) & 'hFF, 'h1000 + f * 64, f, 0);
    issue('h20, 'h7F, 'hFFF0, 0, 0);
    issue('h20, 'h80, 'h0010, 0, 0);
    issue('h20, 'hFF, 'h0000, 0, 0);
    issue('h20, 'h10, 'hFFFE, 0, 0);
    issue('h21, 'h80, 'hFFFF, 0, 0);
    issue('h1F, 'h40, 'h2000, 0, 0);
    issue('h30, 'h40, 'hFFFE, 4'hF, 0);
    issue('hA0, 'h40, 'h1234, 0, 0);
    for (int k = 0; k < 40; k++)
      issue('h20 + (k % 16), $urandom, $urandom, $urandom, 1);
    for (int k = 0; k < 40; k++)
      issue($urandom, $urandom, $urandom, $urandom, (k % 2) == 1);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", ncyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule